// File: doc/BRIEF.md
# Dual-Event Performance Counter with Shadow

This block watches a wide bundle of single-cycle event strobes and counts two of them at once. Each of its two counters is pointed at one strobe line by a select field that software programs. A control register starts and stops both counters together, clears them, and copies the live totals into a pair of shadow registers. Software reads the shadows at its own pace while counting carries on or stays halted.

Each counter is wider than the register bus. A data register returns the low bus-width bits of a shadow. The bits above that appear in an upper field packed into the same register that holds the event selects. A typical measurement writes the selects, then clears and starts in one write. After a delay it stops and snapshots in one write, then reads the low words and the upper fields and joins them.

The bus is a plain single-cycle write port with a combinational read port. The event bundle is sampled on every clock edge.

Top module: `evt_pair_monitor`

## Requirements
- R1: After reset, both selects, both upper fields, both shadows and the run flag are zero, so every mapped offset reads zero.
- R2: A write to offset 0x0 stores select A in bits [SEL_W-1:0] and select B in bits [2*SEL_W-1:SEL_W], which are bits [7:0] and [15:8] at default sizes. The selects read back from the same positions. Counter A counts only line `evt_in[selA]` and counter B counts only line `evt_in[selB]`.
- R3: While the run flag is set, a counter adds exactly one on each clock edge at which its selected line is high. While the run flag is clear, it holds its value.
- R4: Bit 0 of a write to offset 0x4 is stored as the run flag. Offset 0x4 reads the run flag in bit 0 and zero in every other bit.
- R5: Bit 2 of a write to offset 0x4 clears both live counters at that edge. An event in that cycle is dropped. Writing 0x5 clears both counters, and counting begins at the following edge.
- R6: Bit 1 of a write to offset 0x4 copies each counter into its shadow. The copy includes any event counted at that same edge and is taken before a clear in the same write. Writing 0x2 therefore stops counting and snapshots.
- R7: A shadow changes only on a snapshot write. Clearing, counting and other writes leave it unchanged.
- R8: Offsets 0x8 and 0xC return the low DATA_W bits of shadow A and shadow B. Bits [CNT_W-1:DATA_W] of shadow A appear at offset 0x0 starting at bit 2*SEL_W, and those of shadow B follow directly above. At default sizes these are bits [23:16] and [31:24].
- R9: A counter that holds all ones stays at all ones while events keep arriving, and does not wrap.
- R10: Any address other than 0x0, 0x4, 0x8 and 0xC, including misaligned ones, reads zero. A write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset for read and write |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| evt_in | input | NUM_EVENTS | Per-cycle event strobes |

## Verification
Several behaviours are checked by assertions on every cycle. A clear empties a live counter, and a counter moves by at most one per edge. A halted counter holds, and a saturated counter stays saturated. A snapshot matches the live count, and a shadow holds between snapshots. The run flag follows the control write, and writes to unmapped offsets leave the state unchanged. Other behaviours can only be shown by the bench scenarios. These are the exact totals seen through the selects, including an unselected line that toggles alongside, and the event counted at the snapshot edge. They also include the pre-clear copy when one write both clears and snapshots, and the placement of the upper bits in the select register. A reduced-width second instance pushes counts past the low word and into saturation within a short run.

// File: rtl/evtmon_pkg.sv
// Package: shared constants and types for the dual-event counter.
// Assumes word offsets on a byte-addressed bus.
package evtmon_pkg;

    localparam int NUM_CTR  = 2;
    localparam int OFS_CFG  = 'h0;
    localparam int OFS_CTL  = 'h4;
    localparam int OFS_CNTA = 'h8;
    localparam int OFS_CNTB = 'hC;

    // Control word bit positions (decoded by software, so kept fixed).
    localparam int CTL_RUN  = 0;
    localparam int CTL_SNAP = 1;
    localparam int CTL_CLR  = 2;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_CFG,
        RSEL_CTL,
        RSEL_CNTA,
        RSEL_CNTB
    } reg_sel_e;

    typedef struct packed {
        logic clr;
        logic snap;
    } ctr_cmd_t;

endpackage

// File: rtl/evtmon_counter.sv
// Module: one saturating event counter with its shadow copy.
// Picks one line of the event bundle, counts it while run is high,
// clears on clr, and copies the post-count, pre-clear value on snap.
// Assumes NUM_EVENTS is a power of two so every select is in range.
module evtmon_counter #(
    parameter int NUM_EVENTS = 256,
    parameter int CNT_W      = 40,
    localparam int SEL_W     = $clog2(NUM_EVENTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  evtmon_pkg::ctr_cmd_t  cmd,
    input  logic [SEL_W-1:0]      sel,
    input  logic [NUM_EVENTS-1:0] evt,
    output logic [CNT_W-1:0]      shadow
);

    logic [CNT_W-1:0] live_q;
    logic             hit;
    logic             at_max;
    logic [CNT_W-1:0] advanced;

    // Select the watched line and form the value after this edge's event.
    always_comb begin
        hit      = evt[sel];
        at_max   = &live_q;
        advanced = (run && hit && !at_max) ? live_q + CNT_W'(1) : live_q;
    end

    // Live counter: clear wins over counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (cmd.clr) begin
            live_q <= '0;
        end else begin
            live_q <= advanced;
        end
    end

    // Shadow: capture on snapshot, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (cmd.snap) begin
            shadow <= advanced;
        end
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.clr |=> live_q == '0); // R5
    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd.clr |=> (live_q == $past(live_q)) || (live_q == $past(live_q) + CNT_W'(1))); // R3
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cmd.clr) |=> $stable(live_q)); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((&live_q) && !cmd.clr) |=> (&live_q)); // R9
    AST_SNAP_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.snap && !cmd.clr) |=> shadow == live_q); // R6
    AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd.snap |=> $stable(shadow)); // R7

endmodule

// File: rtl/evtmon_regif.sv
// Module: register decode, stored select/run state and read mux.
// Writes take effect at the strobe's edge; reads are combinational.
// Assumes 2*SEL_W + 2*(CNT_W-DATA_W) fits in DATA_W.
module evtmon_regif #(
    parameter int NUM_EVENTS = 256,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 40,
    parameter int ADDR_W     = 8,
    localparam int SEL_W     = $clog2(NUM_EVENTS),
    localparam int UP_W      = CNT_W - DATA_W,
    localparam int NCTR      = evtmon_pkg::NUM_CTR
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NCTR-1:0][CNT_W-1:0] shadow,
    output logic [NCTR-1:0][SEL_W-1:0] sel,
    output logic                       run,
    output evtmon_pkg::ctr_cmd_t       cmd
);
    import evtmon_pkg::*;

    reg_sel_e rsel;
    logic     wr_cfg;
    logic     wr_ctl;
    logic     wdata_unused;
    logic [DATA_W-1:0] cfg_word;

    // Address decode: exact match only, anything else is unmapped.
    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFS_CFG):  rsel = RSEL_CFG;
            ADDR_W'(OFS_CTL):  rsel = RSEL_CTL;
            ADDR_W'(OFS_CNTA): rsel = RSEL_CNTA;
            ADDR_W'(OFS_CNTB): rsel = RSEL_CNTB;
            default:           rsel = RSEL_NONE;
        endcase
    end

    assign wr_cfg       = bus_wr && (rsel == RSEL_CFG);
    assign wr_ctl       = bus_wr && (rsel == RSEL_CTL);
    assign wdata_unused = ^bus_wdata[DATA_W-1:2*SEL_W];

    // One-cycle command pulses: never stored.
    always_comb begin
        cmd.clr  = wr_ctl && bus_wdata[CTL_CLR];
        cmd.snap = wr_ctl && bus_wdata[CTL_SNAP];
    end

    // Stored selects, written together through the config offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
        end else if (wr_cfg) begin
            for (int i = 0; i < NCTR; i++) begin
                sel[i] <= bus_wdata[i*SEL_W +: SEL_W];
            end
        end
    end

    // Stored run flag, updated by every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (wr_ctl) begin
            run <= bus_wdata[CTL_RUN];
        end
    end

    // Config word: selects low, then each shadow's upper field.
    always_comb begin
        cfg_word = '0;
        for (int i = 0; i < NCTR; i++) begin
            cfg_word[i*SEL_W +: SEL_W]            = sel[i];
            cfg_word[NCTR*SEL_W + i*UP_W +: UP_W] = shadow[i][CNT_W-1:DATA_W];
        end
    end

    // Read mux.
    always_comb begin
        case (rsel)
            RSEL_CFG:  bus_rdata = cfg_word;
            RSEL_CTL:  bus_rdata = DATA_W'(run);
            RSEL_CNTA: bus_rdata = shadow[0][DATA_W-1:0];
            RSEL_CNTB: bus_rdata = shadow[1][DATA_W-1:0];
            default:   bus_rdata = '0;
        endcase
    end

    AST_RUN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> run == $past(bus_wdata[CTL_RUN])); // R4
    AST_SEL_ONLY_BY_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg |=> $stable(sel)); // R2
    AST_UNMAPPED_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && rsel == RSEL_NONE) |=> ($stable(run) && $stable(sel))); // R10

endmodule

// File: rtl/evt_pair_monitor.sv
// Module: top of the dual-event performance counter.
// Joins the register interface to one counter per watched event.
// Assumes NUM_EVENTS is a power of two and CNT_W > DATA_W.
module evt_pair_monitor #(
    parameter int NUM_EVENTS = 256,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 40,
    parameter int ADDR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_EVENTS-1:0] evt_in
);
    localparam int SEL_W = $clog2(NUM_EVENTS);
    localparam int NCTR  = evtmon_pkg::NUM_CTR;

    logic [NCTR-1:0][SEL_W-1:0] sel;
    logic [NCTR-1:0][CNT_W-1:0] shadow;
    logic                       run;
    evtmon_pkg::ctr_cmd_t       cmd;

    evtmon_regif #(
        .NUM_EVENTS(NUM_EVENTS),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .shadow   (shadow),
        .sel      (sel),
        .run      (run),
        .cmd      (cmd)
    );

    // One counter per watched event.
    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        evtmon_counter #(
            .NUM_EVENTS(NUM_EVENTS),
            .CNT_W     (CNT_W)
        ) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .cmd   (cmd),
            .sel   (sel[g]),
            .evt   (evt_in),
            .shadow(shadow[g])
        );
    end

endmodule

// File: tb/evt_pair_monitor_bench.sv
module evt_pair_monitor_bench;
    localparam int W_EV = 256, W_D = 32, W_C = 40, W_A = 8;
    localparam int N_EV = 4,   N_D = 8,  N_C = 10, N_A = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n;
    logic [W_A-1:0]  w_addr;
    logic            w_wr;
    logic [W_D-1:0]  w_wdata, w_rdata;
    logic [W_EV-1:0] w_ev;
    logic [N_A-1:0]  n_addr;
    logic            n_wr;
    logic [N_D-1:0]  n_wdata, n_rdata;
    logic [N_EV-1:0] n_ev;

    evt_pair_monitor u_evt_pair_monitor (
        .clk(clk), .rst_n(rst_n), .bus_addr(w_addr), .bus_wr(w_wr),
        .bus_wdata(w_wdata), .bus_rdata(w_rdata), .evt_in(w_ev));

    evt_pair_monitor #(.NUM_EVENTS(N_EV), .DATA_W(N_D), .CNT_W(N_C), .ADDR_W(N_A))
    u_evt_pair_monitor_narrow (
        .clk(clk), .rst_n(rst_n), .bus_addr(n_addr), .bus_wr(n_wr),
        .bus_wdata(n_wdata), .bus_rdata(n_rdata), .evt_in(n_ev));

    typedef struct {
        bit          narrow;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Monitor: compare queued expectations shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                sb_item_t    it;
                logic [31:0] got;
                it  = sb_q.pop_front();
                got = it.narrow ? {24'b0, n_rdata} : w_rdata;
                n_cmp++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    // Driver tasks: all are entered at a falling edge and leave at one.
    task automatic wr(input bit narrow, input logic [31:0] a, input logic [31:0] d);
        if (narrow) begin n_addr = a[N_A-1:0]; n_wdata = d[N_D-1:0]; n_wr = 1'b1; end
        else        begin w_addr = a[W_A-1:0]; w_wdata = d;           w_wr = 1'b1; end
        @(negedge clk);
        n_wr = 1'b0;
        w_wr = 1'b0;
    endtask

    task automatic rd(input bit narrow, input logic [31:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        if (narrow) n_addr = a[N_A-1:0];
        else        w_addr = a[W_A-1:0];
        it.narrow = narrow;
        it.exp    = e;
        it.tag    = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; w_addr = '0; w_wr = 1'b0; w_wdata = '0; w_ev = '0;
        n_addr = '0; n_wr = 1'b0; n_wdata = '0; n_ev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at every mapped offset.
        rd(0, 'h0, 0, "R1 cfg after reset");
        rd(0, 'h4, 0, "R1 ctl after reset");
        rd(0, 'h8, 0, "R1 cntA after reset");
        rd(0, 'hC, 0, "R1 cntB after reset");

        // R2: selects 40 and 104.
        wr(0, 'h0, 32'h0000_6828);
        rd(0, 'h0, 32'h0000_6828, "R2 select readback");

        // R5/R4: clear and start.
        wr(0, 'h4, 32'h5);
        rd(0, 'h4, 1, "R4 run reads back");
        w_ev[40] = 1'b1; w_ev[104] = 1'b1; w_ev[41] = 1'b1;
        repeat (10) @(negedge clk);
        w_ev[104] = 1'b0;
        repeat (15) @(negedge clk);
        wr(0, 'h4, 32'h2);            // snapshot edge still sees line 40 high
        w_ev[40] = 1'b0; w_ev[41] = 1'b0;
        rd(0, 'h8, 26, "R6 cntA includes snapshot-edge event");
        rd(0, 'hC, 10, "R3 cntB counts selected line only");
        rd(0, 'h4, 0, "R6 snapshot write stops run");

        // R3: halted counters ignore events.
        w_ev[40] = 1'b1;
        repeat (5) @(negedge clk);
        w_ev[40] = 1'b0;
        wr(0, 'h4, 32'h2);
        rd(0, 'h8, 26, "R3 halted counter holds");

        // R7: clear leaves shadows alone.
        wr(0, 'h4, 32'h5);
        w_ev[40] = 1'b1;
        repeat (7) @(negedge clk);
        w_ev[40] = 1'b0;
        rd(0, 'h8, 26, "R7 shadowA unchanged by clear and counting");
        rd(0, 'hC, 10, "R7 shadowB unchanged by clear and counting");
        wr(0, 'h4, 32'h3);
        rd(0, 'h4, 1, "R4 run kept by snapshot with bit0");
        rd(0, 'h8, 7, "R6 snapshot while running");
        rd(0, 'hC, 0, "R6 cntB zero after clear");

        // R6/R5: snapshot and clear together take the pre-clear value.
        w_ev[104] = 1'b1;
        repeat (4) @(negedge clk);
        w_ev[104] = 1'b0;
        wr(0, 'h4, 32'h6);
        rd(0, 'hC, 4, "R6 combined write keeps pre-clear cntB");
        rd(0, 'h8, 7, "R6 combined write keeps pre-clear cntA");
        rd(0, 'h4, 0, "R4 run cleared");
        wr(0, 'h4, 32'h2);
        rd(0, 'h8, 0, "R5 live counter was cleared");

        // R10: unmapped and misaligned addresses.
        rd(0, 'h10, 0, "R10 unmapped read");
        rd(0, 'h1, 0, "R10 misaligned read");
        wr(0, 'h10, 32'hFFFF_FFFF);
        wr(0, 'h5, 32'h7);
        rd(0, 'h0, 32'h0000_6828, "R10 selects untouched");
        rd(0, 'h4, 0, "R10 run untouched");

        // Narrow instance: R8 upper fields and R9 saturation.
        wr(1, 'h0, 32'h0D);           // selA=1, selB=3
        rd(1, 'h0, 32'h0D, "R2 narrow select readback");
        wr(1, 'h4, 32'h5);
        n_ev[1] = 1'b1; n_ev[3] = 1'b1; n_ev[2] = 1'b1;
        repeat (300) @(negedge clk);
        n_ev[3] = 1'b0;
        repeat (800) @(negedge clk);
        n_ev = '0;
        wr(1, 'h4, 32'h2);
        rd(1, 'h8, 32'hFF, "R9 saturated low word");
        rd(1, 'hC, 32'h2C, "R8 cntB low word");
        rd(1, 'h0, 32'h7D, "R8 upper fields beside selects");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule